// File: doc/BRIEF.md
# Frequent Pattern Word Decompressor

This block turns one compressed cache block back into its plain form: `WORDS` (default sixteen) 32-bit words. The compressed block is a packed bitstream with the earliest code in the most significant bits. Each code is a 3-bit pattern selector followed directly by a data field. The field width depends on the selector: 3, 4, 8, 16 or 32 bits. The patterns are a run of zero words and sign-extended small values of 4, 8 or 16 bits. There is also a halfword placed in the upper half, a pair of sign-extended bytes, a byte copied into every lane, and a raw word.

The whole compressed block is loaded in one handshake. The block then decodes one code at a time and presents the words in order on a valid/ready stream, at most one word per cycle. A zero-run code yields several zero words from one code, one per accepted transfer. After the last word has been accepted, a done flag stays up until the next block is loaded.

Top module: `fpw_decomp`

## Requirements
- R1: After reset, out_valid and done are low and in_ready is high.
- R2: Selector 000 yields N zero words, where N is the 3-bit field plus one (runs of 1 to 8 words).
- R3: Selector 001 takes 4 data bits and yields them sign-extended to 32 bits.
- R4: Selector 010 takes 8 data bits and yields them sign-extended to 32 bits.
- R5: Selector 011 takes 16 data bits and yields them sign-extended to 32 bits.
- R6: Selector 100 takes 16 data bits that form bits 31:16 of the word, and bits 15:0 are zero.
- R7: Selector 101 takes 16 data bits. The first byte, sign-extended, fills bits 31:16. The second byte, sign-extended, fills bits 15:0.
- R8: Selector 110 takes 8 data bits and copies them into all four byte lanes.
- R9: Selector 111 takes 32 data bits and yields them unchanged.
- R10: Codes are packed back to back with no gaps, MSB first, starting at in_bits[WORDS*35-1]. The words appear in code order, one per out_valid/out_ready handshake, and out_valid stays high from the load until the last word is accepted.
- R11: While out_valid is high and out_ready is low, out_valid and out_data hold their values.
- R12: A zero run that would reach past the last word is cut at the end of the block. After exactly WORDS words, done goes high, out_valid goes low and in_ready goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Compressed block offered |
| in_ready | output | 1 | Block can be loaded (idle or finished) |
| in_bits | input | WORDS*35 | Packed compressed block, first code at the MSB |
| out_valid | output | 1 | out_data carries a decoded word |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Decoded word |
| done | output | 1 | All words of the block emitted |

## Verification
Random blocks mix all eight selectors with random field values, so every field width meets every bit alignment in the stream and a wrong consumed length shows up as corrupted words that follow. A block made only of raw words fills the input to its last bit and exposes errors at the low end of the buffer. Blocks that end in a long zero run, and blocks made of two full-length runs, separate correct clipping at the block end from a run count that is off by one. Random out_ready stalls tell a held word apart from one that advances without a handshake.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    localparam int WORD_W = 32;
    localparam int SEL_W  = 3;
    localparam int CODE_MAX = SEL_W + WORD_W;

    typedef enum logic [2:0] {
        SEL_ZRUN  = 3'b000,
        SEL_SE4   = 3'b001,
        SEL_SE8   = 3'b010,
        SEL_SE16  = 3'b011,
        SEL_HIHW  = 3'b100,
        SEL_BPAIR = 3'b101,
        SEL_BREP  = 3'b110,
        SEL_RAW   = 3'b111
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/fpw_expand.sv
module fpw_expand
    import fpw_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] field,
    output logic [WORD_W-1:0] word,
    output logic [5:0]        code_len
);
    always_comb begin
        word     = '0;
        code_len = 6'(SEL_W);
        unique case (sel_e'(sel))
            SEL_ZRUN: begin
                word     = '0;
                code_len = 6'(SEL_W + 3);
            end
            SEL_SE4: begin
                word     = {{28{field[31]}}, field[31:28]};
                code_len = 6'(SEL_W + 4);
            end
            SEL_SE8: begin
                word     = {{24{field[31]}}, field[31:24]};
                code_len = 6'(SEL_W + 8);
            end
            SEL_SE16: begin
                word     = {{16{field[31]}}, field[31:16]};
                code_len = 6'(SEL_W + 16);
            end
            SEL_HIHW: begin
                word     = {field[31:16], 16'h0000};
                code_len = 6'(SEL_W + 16);
            end
            SEL_BPAIR: begin
                word     = {{8{field[31]}}, field[31:24], {8{field[23]}}, field[23:16]};
                code_len = 6'(SEL_W + 16);
            end
            SEL_BREP: begin
                word     = {4{field[31:24]}};
                code_len = 6'(SEL_W + 8);
            end
            SEL_RAW: begin
                word     = field;
                code_len = 6'(SEL_W + WORD_W);
            end
            default: begin
                word     = '0;
                code_len = 6'(SEL_W);
            end
        endcase
    end
endmodule

// File: rtl/fpw_run_clip.sv
module fpw_run_clip #(
    parameter int CNT_W = 5
) (
    input  logic [2:0]       run_code,
    input  logic [CNT_W-1:0] words_left,
    output logic [3:0]       extra
);
    int unsigned want;
    int unsigned avail;

    always_comb begin
        want  = 32'(run_code) + 32'd1;
        avail = 32'(words_left);
        if (want > avail) begin
            extra = 4'(avail - 32'd1);
        end else begin
            extra = 4'(want - 32'd1);
        end
    end
endmodule

// File: rtl/fpw_decomp.sv
module fpw_decomp
    import fpw_pkg::*;
#(
    parameter int WORDS = 16,
    localparam int TOTAL = WORDS * CODE_MAX,
    localparam int CNT_W = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TOTAL-1:0]  in_bits,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              done
);
    typedef struct packed {
        state_e           st;
        logic [TOTAL-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       run_left;
    } regs_t;

    regs_t d, q;

    logic [CODE_MAX-1:0] window;
    logic [WORD_W-1:0]   dec_word;
    logic [5:0]          code_len;
    logic [CNT_W-1:0]    words_left;
    logic [3:0]          run_extra;

    assign window     = q.bits[TOTAL-1 -: CODE_MAX];
    assign words_left = CNT_W'(WORDS) - q.cnt;

    fpw_expand i_expand (
        .sel      (window[CODE_MAX-1 -: SEL_W]),
        .field    (window[WORD_W-1:0]),
        .word     (dec_word),
        .code_len (code_len)
    );

    fpw_run_clip #(.CNT_W(CNT_W)) i_run_clip (
        .run_code   (window[WORD_W-1 -: 3]),
        .words_left (words_left),
        .extra      (run_extra)
    );

    assign in_ready  = (q.st != ST_RUN);
    assign out_valid = (q.st == ST_RUN);
    assign done      = (q.st == ST_DONE);
    assign out_data  = (q.run_left != 4'd0) ? '0 : dec_word;

    always_comb begin
        d = q;
        if (in_valid && in_ready) begin
            d.st       = ST_RUN;
            d.bits     = in_bits;
            d.cnt      = '0;
            d.run_left = '0;
        end else if (out_valid && out_ready) begin
            d.cnt = q.cnt + CNT_W'(1);
            if (q.run_left != 4'd0) begin
                d.run_left = q.run_left - 4'd1;
            end else begin
                d.bits = q.bits << code_len;
                if (window[CODE_MAX-1 -: SEL_W] == SEL_ZRUN) begin
                    d.run_left = run_extra;
                end
            end
            if (q.cnt == CNT_W'(WORDS - 1)) begin
                d.st = ST_DONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.bits     <= '0;
            q.cnt      <= '0;
            q.run_left <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/fpw_decomp_chk.sv
module fpw_decomp_chk #(
    parameter int WORDS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        done
);
    localparam int CW = $clog2(WORDS + 1) + 1;
    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (in_valid && in_ready) begin
            seen_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q <= seen_q + CW'(1);
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && in_ready));

    p_done_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen_q == CW'(WORDS)));

    p_no_overrun_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= CW'(WORDS)) |-> !out_valid);

    p_stream_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_idle_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && done));
endmodule

bind fpw_decomp fpw_decomp_chk #(.WORDS(WORDS)) i_chk (.*);

// File: tb/test_fpw_decomp.sv
module test_fpw_decomp;
    localparam int WORDS = 16;
    localparam int TOTAL = WORDS * 35;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [TOTAL-1:0] in_bits = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [31:0]      out_data;
    logic             done;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [TOTAL-1:0] stream;
    int               used;
    logic [31:0]      exp_w [WORDS];
    string            exp_tag [WORDS];
    int               nexp;

    always #2.5 clk = ~clk;

    fpw_decomp #(.WORDS(WORDS)) i_fpw_decomp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int data_len(input int k);
        case (k)
            0: return 3;
            1: return 4;
            2, 6: return 8;
            3, 4, 5: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic put_code(input int k, input logic [31:0] data);
        int len = data_len(k);
        logic [34:0] code = (35'(k) << len) | 35'(data);
        stream = (stream << (3 + len)) | TOTAL'(code);
        used += 3 + len;
    endtask

    task automatic push_exp(input logic [31:0] w, input string tag);
        exp_w[nexp] = w;
        exp_tag[nexp] = tag;
        nexp++;
    endtask

    // k = selector, rl = run length for zero runs
    task automatic add_word(input int k, input int rl);
        logic [31:0] v = $urandom;
        case (k)
            0: begin
                put_code(0, 32'(rl - 1));
                for (int i = 0; i < rl; i++) begin
                    if (nexp < WORDS) push_exp(32'h0, (rl > WORDS - nexp + i) ? "R12" : "R2");
                end
            end
            1: begin put_code(1, {28'h0, v[3:0]});  push_exp({{28{v[3]}}, v[3:0]}, "R3"); end
            2: begin put_code(2, {24'h0, v[7:0]});  push_exp({{24{v[7]}}, v[7:0]}, "R4"); end
            3: begin put_code(3, {16'h0, v[15:0]}); push_exp({{16{v[15]}}, v[15:0]}, "R5"); end
            4: begin put_code(4, {16'h0, v[15:0]}); push_exp({v[15:0], 16'h0}, "R6"); end
            5: begin
                put_code(5, {16'h0, v[15:0]});
                push_exp({{8{v[15]}}, v[15:8], {8{v[7]}}, v[7:0]}, "R7");
            end
            6: begin put_code(6, {24'h0, v[7:0]}); push_exp({4{v[7:0]}}, "R8"); end
            default: begin put_code(7, v); push_exp(v, "R9"); end
        endcase
    endtask

    // mode 0 random, 1 all raw, 2 mixed then long run clipped, 3 two full runs
    task automatic build(input int mode);
        stream = '0; used = 0; nexp = 0;
        while (nexp < WORDS) begin
            case (mode)
                1: add_word(7, 0);
                2: if (nexp < 12) add_word(1 + (nexp % 6), 0); else add_word(0, 8);
                3: add_word(0, 8);
                default: add_word(int'($urandom % 8), 1 + int'($urandom % 8));
            endcase
        end
        stream = stream << (TOTAL - used);
    endtask

    task automatic run_block(input int mode);
        int idx = 0;
        bit held = 1'b0;
        logic [31:0] held_val = '0;
        int guard = 0;
        build(mode);
        @(negedge clk);
        in_bits = stream; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (idx < WORDS && guard < 400) begin
            guard++;
            out_ready = ($urandom % 4) != 0;
            #1;
            check(out_valid == 1'b1, "R10 valid", 32'(out_valid), 32'd1);
            if (held) check(out_data == held_val, "R11 hold", out_data, held_val);
            if (out_ready) begin
                check(out_data == exp_w[idx], exp_tag[idx], out_data, exp_w[idx]);
                idx++;
                held = 1'b0;
            end else begin
                held = 1'b1;
                held_val = out_data;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        #1;
        check(done && !out_valid && in_ready, "R12 end", {29'h0, done, out_valid, in_ready}, 32'h5);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #12;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid && !done && in_ready, "R1 reset", {29'h0, done, out_valid, in_ready}, 32'h1);
        run_block(1);
        run_block(2);
        run_block(3);
        for (int b = 0; b < 40; b++) run_block(0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule